// File: doc/BRIEF.md
# SDRAM Refresh and Self-Refresh Sequencer

This block keeps an SDRAM's contents alive. A free-running interval timer raises one refresh obligation every `INTERVAL` clock cycles. Obligations that cannot be served at once are counted, up to `PEND_MAX`, so a busy memory system loses none of them. While any obligation is outstanding, the sequencer requests the command bus from the memory arbiter. Once the arbiter grants it, the sequencer closes every open row with a precharge-all command if the bank tracker reports that a bank is still active. It waits for the banks to become idle and then drives an auto-refresh command. For the following `TRFC` cycles it holds only NOPs, and the bus stays requested.

A low-power request travels over the same bus handshake. It is acted on only while no refresh obligation is outstanding. The sequencer drives the self-refresh entry command with the clock enable low, keeps the clock enable low, and reports busy. On a wake request it raises the clock enable and keeps the bus, issuing only NOPs for `TRFC` cycles, before it drops busy. The interval timer is frozen for the whole sleep period, because the memory refreshes itself then.

The command pins are ordered chip select, row strobe, column strobe, write enable, all active low. NOP is 0111, auto refresh is 0001 with clock enable high, precharge-all is 0010 with `allBanks` high, and self-refresh entry is 0001 with clock enable low.

Top module: `sdram_refresh_seq`

## Requirements
- R1: With the bus granted and the banks idle, consecutive auto-refresh commands appear exactly `INTERVAL` cycles apart.
- R2: Auto refresh is driven as pins 0001 (cs, ras, cas, we) with `cke` high in that cycle and in the cycle before. After reset `cke` is high, the pins show NOP (0111), and `busReq` and `busy` are low.
- R3: If `banksIdle` is low when the bus is granted, the sequencer drives precharge-all (pins 0010 with `allBanks` high). It then issues nothing but NOP until `banksIdle` rises, and only after that drives the refresh or self-refresh entry.
- R4: In the `TRFC`-1 cycles that follow an auto-refresh command, the pins show NOP and `busReq` stays high. In the cycle after those, `busReq` falls if nothing is outstanding.
- R5: Obligations that arrive while no grant is given accumulate, saturating at `PEND_MAX`. A later grant serves exactly min(k, `PEND_MAX`) refreshes for k intervals withheld.
- R6: An interval tick that lands in the same cycle as the issue of a refresh is neither lost nor counted twice.
- R7: `busReq` is high whenever the sequencer drives a command other than NOP, and it stays high from grant until the operation's NOP wait has ended.
- R8: A granted sleep request with no obligation outstanding and idle banks drives pins 0001 with `cke` low. `cke` then stays low and `busy` high, with only NOP on the pins, until a wake request arrives.
- R9: No refresh is issued during self refresh. The first new refresh request appears exactly `INTERVAL` cycles after the post-exit wait ends.
- R10: On a wake request, `cke` is high in the next cycle. `busy` stays high with NOP pins for `TRFC` cycles counted from that cycle, and then falls.
- R11: A sleep request made while a refresh is outstanding is served only after that refresh has been issued.
- R12: A wake request outside self refresh has no effect: `cke` stays high, `busy` stays low and the pins show NOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| banksIdle | input | 1 | From the bank tracker: every bank is precharged |
| busGrant | input | 1 | Arbiter grants the command bus; held while busReq is high |
| sleepReq | input | 1 | Request to enter self refresh |
| wakeReq | input | 1 | Request to leave self refresh |
| busReq | output | 1 | Sequencer needs or holds the command bus |
| busy | output | 1 | High from self-refresh entry until the post-exit wait ends |
| cke | output | 1 | Memory clock enable |
| csN | output | 1 | Chip select, active low |
| rasN | output | 1 | Row strobe, active low |
| casN | output | 1 | Column strobe, active low |
| weN | output | 1 | Write enable, active low |
| allBanks | output | 1 | Precharge applies to all banks |

## Verification
Two functions can fall in the same cycle: the interval timer adding an obligation, and the sequencer retiring one by issuing a refresh. The bench locates the timer phase from the rising edge of `busReq` while the grant is withheld. It then sweeps the grant over seven offsets around the point where the issue cycle lands exactly on the next tick. In every case the number of refreshes in a fixed window must be two; a lost or doubled obligation changes that count. The saturating backlog gets a similar sweep over the number of withheld intervals.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHECK,
    ST_WAITP,
    ST_RFC,
    ST_SELF,
    ST_EXIT
  } seqState_t;

  // Strobes from the control to the datapath, valid for one cycle
  typedef struct packed {
    logic issueRef;
    logic issuePall;
    logic issueSref;
    logic raiseCke;
    logic loadWait;
    logic holdTimer;
  } seqStrobe_t;

  // Pin order: cs, ras, cas, we (all active low)
  localparam logic [3:0] CMD_NOP       = 4'b0111;
  localparam logic [3:0] CMD_REFRESH   = 4'b0001;
  localparam logic [3:0] CMD_PRECHARGE = 4'b0010;

endpackage

// File: rtl/rfsh_datapath.sv
module rfsh_datapath
  import rfsh_pkg::*;
#(
  parameter int INTERVAL = 1560,
  parameter int TRFC     = 7,
  parameter int PEND_MAX = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  seqStrobe_t strobe,
  output logic       pendNz,
  output logic       waitDone,
  output logic [3:0] cmdQ,
  output logic       ckeQ,
  output logic       allBanksQ
);

  localparam int TMR_W  = (INTERVAL > 1) ? $clog2(INTERVAL) : 1;
  localparam int PEND_W = $clog2(PEND_MAX + 1);
  localparam int WAIT_W = $clog2(TRFC + 1);

  logic [TMR_W-1:0]  timer;
  logic              tick;
  logic [PEND_W-1:0] pending;
  logic              atMax;
  logic [WAIT_W-1:0] waitCnt;

  // Interval timer, frozen at zero while the device refreshes itself
  assign tick = !strobe.holdTimer && (timer == TMR_W'(INTERVAL - 1));

  always_ff @(posedge clk) begin
    if (!rstN)                          timer <= '0;
    else if (strobe.holdTimer || tick)  timer <= '0;
    else                                timer <= timer + 1'b1;
  end

  // Backlog of owed refreshes; a tick and an issue together cancel out
  assign atMax  = (pending == PEND_W'(PEND_MAX));
  assign pendNz = (pending != '0);

  always_ff @(posedge clk) begin
    if (!rstN)                                      pending <= '0;
    else if (strobe.holdTimer)                      pending <= '0;
    else if (tick && !strobe.issueRef && !atMax)    pending <= pending + 1'b1;
    else if (!tick && strobe.issueRef && pendNz)    pending <= pending - 1'b1;
  end

  // NOP lockout counter, shared by refresh and self-refresh exit
  always_ff @(posedge clk) begin
    if (!rstN)                 waitCnt <= '0;
    else if (strobe.loadWait)  waitCnt <= WAIT_W'(TRFC);
    else if (waitCnt != '0)    waitCnt <= waitCnt - 1'b1;
  end

  assign waitDone = (waitCnt == WAIT_W'(1));

  // Registered command pins and clock enable
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdQ      <= CMD_NOP;
      allBanksQ <= 1'b0;
      ckeQ      <= 1'b1;
    end else begin
      if (strobe.issueRef || strobe.issueSref) cmdQ <= CMD_REFRESH;
      else if (strobe.issuePall)               cmdQ <= CMD_PRECHARGE;
      else                                     cmdQ <= CMD_NOP;
      allBanksQ <= strobe.issuePall;
      if (strobe.issueSref)     ckeQ <= 1'b0;
      else if (strobe.raiseCke) ckeQ <= 1'b1;
    end
  end

endmodule

// File: rtl/rfsh_control.sv
module rfsh_control
  import rfsh_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       busGrant,
  input  logic       sleepReq,
  input  logic       wakeReq,
  input  logic       banksIdle,
  input  logic       ckeQ,
  input  logic       pendNz,
  input  logic       waitDone,
  output seqStrobe_t strobe,
  output logic       busReq,
  output logic       busy
);

  seqState_t state, nextState;
  logic      opSleep;
  logic      wantBus;

  assign wantBus = pendNz || sleepReq;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      opSleep <= 1'b0;
    end else begin
      state <= nextState;
      if (state == ST_IDLE && wantBus && busGrant) opSleep <= !pendNz;
    end
  end

  always_comb begin
    strobe           = '0;
    nextState        = state;
    strobe.holdTimer = (state == ST_SELF) || (state == ST_EXIT);
    case (state)
      ST_IDLE: begin
        if (wantBus && busGrant) nextState = ST_CHECK;
      end
      ST_CHECK: begin
        if (banksIdle && ckeQ) begin
          if (opSleep) begin
            strobe.issueSref = 1'b1;
            nextState        = ST_SELF;
          end else begin
            strobe.issueRef = 1'b1;
            strobe.loadWait = 1'b1;
            nextState       = ST_RFC;
          end
        end else if (!banksIdle) begin
          strobe.issuePall = 1'b1;
          nextState        = ST_WAITP;
        end
      end
      ST_WAITP: begin
        if (banksIdle) nextState = ST_CHECK;
      end
      ST_RFC: begin
        if (waitDone) nextState = ST_IDLE;
      end
      ST_SELF: begin
        if (wakeReq) begin
          strobe.raiseCke = 1'b1;
          strobe.loadWait = 1'b1;
          nextState       = ST_EXIT;
        end
      end
      ST_EXIT: begin
        if (waitDone) nextState = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  assign busReq = (state == ST_IDLE) ? wantBus : 1'b1;
  assign busy   = (state == ST_SELF) || (state == ST_EXIT);

endmodule

// File: rtl/sdram_refresh_seq.sv
module sdram_refresh_seq
  import rfsh_pkg::*;
#(
  parameter int INTERVAL = 1560,
  parameter int TRFC     = 7,
  parameter int PEND_MAX = 8
) (
  input  logic clk,
  input  logic rstN,
  input  logic banksIdle,
  input  logic busGrant,
  input  logic sleepReq,
  input  logic wakeReq,
  output logic busReq,
  output logic busy,
  output logic cke,
  output logic csN,
  output logic rasN,
  output logic casN,
  output logic weN,
  output logic allBanks
);

  seqStrobe_t strobe;
  logic       pendNz;
  logic       waitDone;
  logic [3:0] cmdQ;
  logic       ckeQ;

  rfsh_control uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .busGrant (busGrant),
    .sleepReq (sleepReq),
    .wakeReq  (wakeReq),
    .banksIdle(banksIdle),
    .ckeQ     (ckeQ),
    .pendNz   (pendNz),
    .waitDone (waitDone),
    .strobe   (strobe),
    .busReq   (busReq),
    .busy     (busy)
  );

  rfsh_datapath #(
    .INTERVAL(INTERVAL),
    .TRFC    (TRFC),
    .PEND_MAX(PEND_MAX)
  ) uData (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .pendNz   (pendNz),
    .waitDone (waitDone),
    .cmdQ     (cmdQ),
    .ckeQ     (ckeQ),
    .allBanksQ(allBanks)
  );

  assign {csN, rasN, casN, weN} = cmdQ;
  assign cke = ckeQ;

endmodule

// File: rtl/rfsh_checker.sv
module rfsh_checker
  import rfsh_pkg::*;
#(
  parameter int TRFC = 7
) (
  input logic clk,
  input logic rstN,
  input logic banksIdle,
  input logic busReq,
  input logic busy,
  input logic cke,
  input logic csN,
  input logic rasN,
  input logic casN,
  input logic weN,
  input logic allBanks
);

  localparam int CW = $clog2(TRFC + 1);

  logic [3:0]    cmd;
  logic          isRef, isSref, isPall;
  logic [CW-1:0] sinceRef;

  assign cmd    = {csN, rasN, casN, weN};
  assign isRef  = (cmd == CMD_REFRESH) && cke;
  assign isSref = (cmd == CMD_REFRESH) && !cke;
  assign isPall = (cmd == CMD_PRECHARGE);

  // Cycles since the last auto refresh on the pins, saturating at TRFC
  always_ff @(posedge clk) begin
    if (!rstN)                       sinceRef <= CW'(TRFC);
    else if (isRef)                  sinceRef <= CW'(1);
    else if (sinceRef < CW'(TRFC))   sinceRef <= sinceRef + 1'b1;
  end

  // R2: refresh only after a cycle with the clock enable high
  a_r2_cke_before_refresh: assert property (@(posedge clk) disable iff (!rstN)
    isRef |-> $past(cke));

  // R3: precharge always targets every bank
  a_r3_precharge_all: assert property (@(posedge clk) disable iff (!rstN)
    isPall |-> allBanks);

  // R3: refresh and self-refresh entry only follow an idle-banks cycle
  a_r3_banks_idle_first: assert property (@(posedge clk) disable iff (!rstN)
    (isRef || isSref) |-> $past(banksIdle));

  // R4: NOP lockout after a refresh
  a_r4_nop_lockout: assert property (@(posedge clk) disable iff (!rstN)
    (!isRef && sinceRef < CW'(TRFC)) |-> (cmd == CMD_NOP));

  // R4: bus kept through the lockout
  a_r4_bus_held: assert property (@(posedge clk) disable iff (!rstN)
    (!isRef && sinceRef < CW'(TRFC)) |-> busReq);

  // R7: any real command comes with the bus request up
  a_r7_cmd_with_request: assert property (@(posedge clk) disable iff (!rstN)
    (cmd != CMD_NOP) |-> busReq);

  // R8: clock enable low only while reporting busy
  a_r8_cke_low_busy: assert property (@(posedge clk) disable iff (!rstN)
    !cke |-> busy);

  // R8: entry command comes with busy already high
  a_r8_entry_busy: assert property (@(posedge clk) disable iff (!rstN)
    isSref |-> busy);

endmodule

bind sdram_refresh_seq rfsh_checker #(.TRFC(TRFC)) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .banksIdle(banksIdle),
  .busReq   (busReq),
  .busy     (busy),
  .cke      (cke),
  .csN      (csN),
  .rasN     (rasN),
  .casN     (casN),
  .weN      (weN),
  .allBanks (allBanks)
);

// File: tb/sdram_refresh_seq_test.sv
module sdram_refresh_seq_test;

  localparam int INTERVAL = 40;
  localparam int TRFC     = 4;
  localparam int PEND_MAX = 3;
  localparam int WATCHDOG = 150000;

  logic clk = 1'b0;
  logic rstN, banksIdle, busGrant, sleepReq, wakeReq;
  logic busReq, busy, cke, csN, rasN, casN, weN, allBanks;

  int cyc    = 0;
  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  sdram_refresh_seq #(
    .INTERVAL(INTERVAL),
    .TRFC    (TRFC),
    .PEND_MAX(PEND_MAX)
  ) uut (
    .clk      (clk),
    .rstN     (rstN),
    .banksIdle(banksIdle),
    .busGrant (busGrant),
    .sleepReq (sleepReq),
    .wakeReq  (wakeReq),
    .busReq   (busReq),
    .busy     (busy),
    .cke      (cke),
    .csN      (csN),
    .rasN     (rasN),
    .casN     (casN),
    .weN      (weN),
    .allBanks (allBanks)
  );

  always #4 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [3:0] pins();
    return {csN, rasN, casN, weN};
  endfunction

  function automatic bit isRef();
    return (pins() == 4'b0001) && cke;
  endfunction

  function automatic bit isSref();
    return (pins() == 4'b0001) && !cke;
  endfunction

  task automatic report();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    if (cyc == WATCHDOG && !done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      report();
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  // Grant until nothing is outstanding, then withdraw the grant
  task automatic drain();
    busGrant = 1'b1;
    step();
    for (int i = 0; i < 300 && busReq; i++) step();
    busGrant = 1'b0;
  endtask

  // With the grant withheld, wait for the cycle an obligation appears
  task automatic syncTick();
    step();
    for (int i = 0; i < 300 && !busReq; i++) step();
  endtask

  task automatic countRefs(input int n, output int cnt);
    cnt = 0;
    for (int i = 0; i < n; i++) begin
      step();
      if (isRef()) cnt++;
    end
  endtask

  initial begin
    int last, found, bad, n, w;
    rstN = 1'b0; banksIdle = 1'b1; busGrant = 1'b0;
    sleepReq = 1'b0; wakeReq = 1'b0;
    repeat (5) step();
    rstN = 1'b1;
    step();

    // R2 reset state
    check("R2 reset cke", int'(cke), 1);
    check("R2 reset pins NOP", int'(pins()), 7);
    check("R7 reset busReq", int'(busReq), 0);
    check("R8 reset busy", int'(busy), 0);

    // R1 spacing, R2 encoding, R4 lockout, grant held high
    busGrant = 1'b1;
    last = 0;
    for (int i = 0; i < 4; i++) begin
      found = 0;
      for (int k = 0; k < 200 && !found; k++) begin
        step();
        if (isRef()) found = 1;
      end
      check("R2 refresh seen with cke high", found, 1);
      if (i > 0) check("R1 refresh spacing", cyc - last, INTERVAL);
      last = cyc;
      bad = 0;
      for (int j = 1; j < TRFC; j++) begin
        step();
        if (pins() != 4'b0111 || !busReq) bad++;
      end
      check("R4 NOP lockout with bus held", bad, 0);
      step();
      check("R4 bus released after lockout", int'(busReq), 0);
    end

    // R12 wake outside self refresh
    drain();
    wakeReq = 1'b1;
    bad = 0;
    for (int i = 0; i < 3; i++) begin
      step();
      if (!cke || busy || pins() != 4'b0111) bad++;
    end
    wakeReq = 1'b0;
    check("R12 wake ignored when awake", bad, 0);

    // R5 backlog sweep over withheld intervals
    for (int k = 1; k <= 5; k++) begin
      drain();
      syncTick();
      repeat ((k - 1) * INTERVAL + 5) step();
      busGrant = 1'b1;
      countRefs(30, n);
      check($sformatf("R5 backlog of %0d intervals", k), n, (k < PEND_MAX) ? k : PEND_MAX);
    end

    // R6 tick coinciding with issue, swept over offsets
    for (int d = -3; d <= 3; d++) begin
      drain();
      syncTick();
      repeat (INTERVAL - 2 + d) step();
      busGrant = 1'b1;
      countRefs(30, n);
      check($sformatf("R6 tick/issue offset %0d", d), n, 2);
    end

    // R3 open banks at grant
    drain();
    banksIdle = 1'b0;
    busGrant  = 1'b1;
    found = 0;
    for (int k = 0; k < 100 && !found; k++) begin
      step();
      if (pins() == 4'b0010) found = 1;
    end
    check("R3 precharge issued", found, 1);
    check("R3 precharge targets all banks", int'(allBanks), 1);
    bad = 0;
    for (int i = 0; i < 3; i++) begin
      step();
      if (pins() != 4'b0111) bad++;
    end
    check("R3 NOP while banks busy", bad, 0);
    banksIdle = 1'b1;
    found = 0;
    for (int k = 0; k < 10 && !found; k++) begin
      step();
      if (isRef()) found = 1;
    end
    check("R3 refresh after banks idle", found, 1);

    // R8 entry, R9 frozen timer, R10 exit
    drain();
    sleepReq = 1'b1;
    busGrant = 1'b1;
    found = 0;
    for (int k = 0; k < 40 && !found; k++) begin
      step();
      if (isSref()) found = 1;
    end
    sleepReq = 1'b0;
    check("R8 self-refresh entry", found, 1);
    check("R8 busy at entry", int'(busy), 1);
    bad = 0;
    n = 0;
    for (int i = 0; i < 3 * INTERVAL; i++) begin
      step();
      if (cke || !busy) bad++;
      if (pins() != 4'b0111) n++;
    end
    check("R8 cke low and busy while asleep", bad, 0);
    check("R9 no command while asleep", n, 0);
    busGrant = 1'b0;
    wakeReq  = 1'b1;
    step();
    wakeReq = 1'b0;
    check("R10 cke high after wake", int'(cke), 1);
    check("R10 busy first exit cycle", int'(busy), 1);
    bad = 0;
    for (int j = 2; j <= TRFC; j++) begin
      step();
      if (!busy || !cke || pins() != 4'b0111) bad++;
    end
    check("R10 NOP exit wait", bad, 0);
    step();
    check("R10 busy drops after wait", int'(busy), 0);
    w = 0;
    for (int k = 0; k < 200 && !busReq; k++) begin
      step();
      w++;
    end
    check("R9 first request after exit", w, INTERVAL);

    // R11 sleep behind an outstanding refresh
    drain();
    syncTick();
    sleepReq = 1'b1;
    busGrant = 1'b1;
    last  = -1;
    found = -1;
    for (int k = 0; k < 40 && found < 0; k++) begin
      step();
      if (isRef() && last < 0) last = k;
      if (isSref()) found = k;
    end
    sleepReq = 1'b0;
    check("R11 refresh before sleep", int'(last >= 0 && found > last), 1);
    busGrant = 1'b0;
    wakeReq  = 1'b1;
    step();
    wakeReq = 1'b0;
    for (int k = 0; k < 20 && busy; k++) step();
    check("R10 awake after second exit", int'(busy), 0);

    drain();
    report();
  end

endmodule